// File: doc/BRIEF.md
# Interrupt Coalescing Counter with Delay Timer

This block turns a stream of per-packet completion events into fewer interrupt requests. A down-counter is loaded with a programmed packet threshold. Each completed packet decrements it, and when the count reaches zero the block asks for a completion interrupt and reloads the counter. A second down-counter acts as an inactivity timer. Every completion with a non-zero programmed delay restarts it. If the timer runs out before another packet arrives, the block asks for a delay interrupt, so a partial batch is still reported.

The surrounding register logic provides the threshold and delay fields of the control word. In that word the threshold sits at bits 23:16 and the delay at bits 31:24. The register logic also sends a one-cycle strobe on every control write, and a free-running tick enable sets the timer's time base. The two interrupt outputs are one-cycle set pulses for the status bits, which are held and masked elsewhere. The live counter and timer values are exported so that software can read them back as status.

Top module: `irq_coalescer`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, the counter reads 1, the timer reads 0 and neither set pulse is high.
- R2: A completion decrements the counter. When the decremented value is 0, the completion set pulse is high for one cycle after that clock edge, and the counter is reloaded from the threshold input.
- R3: The counter decrement wraps modulo 256. With a threshold of 0, the first completion gives 255, and only the 256th completion raises the completion set pulse.
- R4: A control-write strobe reloads the counter from the threshold input and raises no set pulse by itself.
- R5: A completion while the delay input is non-zero loads the timer with the delay value. This happens even if the timer is already running, and it wins over a tick in the same cycle.
- R6: A running timer (non-zero value) decrements by one only in cycles where the tick enable is high. Otherwise it holds its value.
- R7: When a tick takes the timer from 1 to 0, the delay set pulse is high for one cycle, and the counter is reloaded from the threshold. Later ticks leave the timer at 0 and raise no further pulse.
- R8: A completion while the delay input is 0 leaves the timer untouched.
- R9: When a completion and a timer expiry fall in the same cycle, the completion's decrement still decides the completion pulse. The counter then ends at the threshold, the delay pulse is raised, and the timer is restarted if the delay is non-zero.
- R10: When a control write and a completion fall in the same cycle, the counter ends at the threshold. The completion pulse is still raised if the decrement reached 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thresh_i | input | 8 | Packet threshold field (control bits 23:16) |
| delay_i | input | 8 | Delay timer field (control bits 31:24) |
| pkt_done_i | input | 1 | One-cycle pulse per completed packet |
| ctrl_wr_i | input | 1 | One-cycle strobe on each control-register write |
| tick_en_i | input | 1 | Timer time-base enable |
| ioc_set_o | output | 1 | Completion interrupt set pulse |
| dly_set_o | output | 1 | Delay interrupt set pulse |
| cnt_o | output | 8 | Live packet counter value |
| tmr_o | output | 8 | Live remaining delay count |

## Verification
The bench builds the block with its default widths: an 8-bit counter and an 8-bit timer, with a post-reset load of 1. At these widths the full 256-completion wrap with a zero threshold takes only a few hundred cycles. Small delays of 1, 2 and 4 ticks make it possible to line up an expiry exactly with a completion or with a counter reload. That is how the same-cycle priority cases are reached.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

  // What the packet counter does on a given clock edge.
  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_DEC    = 2'd1,
    CNT_RELOAD = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/irq_coal_rst_sync.sv
module irq_coal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_coal_timer.sv
module irq_coal_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] delay_i,
  input  logic             pkt_done_i,
  input  logic             tick_en_i,
  output logic             expire_o,
  output logic             dly_set_o,
  output logic [TMR_W-1:0] tmr_o
);

  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             dly_q, dly_d;
  logic             running;
  logic             restart;

  // A non-zero count is the running state; a run ends by reaching zero.
  assign running  = |tmr_q;
  assign restart  = pkt_done_i && (|delay_i);
  assign expire_o = running && tick_en_i && (tmr_q == ONE);

  always_comb begin
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    if (restart) begin
      tmr_d  = delay_i;
      tmr_en = 1'b1;
    end else if (running && tick_en_i) begin
      tmr_d  = tmr_q - ONE;
      tmr_en = 1'b1;
    end
    dly_d = expire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= 1'b0;
    end else begin
      dly_q <= dly_d;
    end
  end

  assign dly_set_o = dly_q;
  assign tmr_o     = tmr_q;

endmodule

// File: rtl/irq_coal_counter.sv
module irq_coal_counter
  import irq_coal_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RST_LOAD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             pkt_done_i,
  input  logic             ctrl_wr_i,
  input  logic             expire_i,
  output logic             ioc_set_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_LOAD);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dec;
  logic             hit;
  logic             ioc_q, ioc_d;
  cnt_op_e          op;

  // The decrement is evaluated first; any reload source then overrides it.
  assign dec = cnt_q - ONE;
  assign hit = pkt_done_i && (dec == '0);

  always_comb begin
    if (ctrl_wr_i || expire_i || hit) begin
      op = CNT_RELOAD;
    end else if (pkt_done_i) begin
      op = CNT_DEC;
    end else begin
      op = CNT_HOLD;
    end
  end

  always_comb begin
    unique case (op)
      CNT_RELOAD: cnt_d = thresh_i;
      CNT_DEC:    cnt_d = dec;
      default:    cnt_d = cnt_q;
    endcase
    ioc_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (op != CNT_HOLD) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioc_q <= 1'b0;
    end else begin
      ioc_q <= ioc_d;
    end
  end

  assign ioc_set_o = ioc_q;
  assign cnt_o     = cnt_q;

endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int CNT_W    = 8,
  parameter int TMR_W    = 8,
  parameter int RST_LOAD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [TMR_W-1:0] delay_i,
  input  logic             pkt_done_i,
  input  logic             ctrl_wr_i,
  input  logic             tick_en_i,
  output logic             ioc_set_o,
  output logic             dly_set_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [TMR_W-1:0] tmr_o
);

  logic rst_sync_n;
  logic expire;

  irq_coal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_coal_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .delay_i    (delay_i),
    .pkt_done_i (pkt_done_i),
    .tick_en_i  (tick_en_i),
    .expire_o   (expire),
    .dly_set_o  (dly_set_o),
    .tmr_o      (tmr_o)
  );

  irq_coal_counter #(.CNT_W(CNT_W), .RST_LOAD(RST_LOAD)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .thresh_i   (thresh_i),
    .pkt_done_i (pkt_done_i),
    .ctrl_wr_i  (ctrl_wr_i),
    .expire_i   (expire),
    .ioc_set_o  (ioc_set_o),
    .cnt_o      (cnt_o)
  );

endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic [CNT_W-1:0] thresh_i,
  input logic [TMR_W-1:0] delay_i,
  input logic             pkt_done_i,
  input logic             ctrl_wr_i,
  input logic             tick_en_i,
  input logic             ioc_set_o,
  input logic             dly_set_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [TMR_W-1:0] tmr_o
);

  p_ioc_reload_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ioc_set_o |-> (cnt_o == $past(thresh_i)));

  p_wr_reload_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl_wr_i |=> (cnt_o == $past(thresh_i)));

  p_tmr_load_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pkt_done_i && (|delay_i)) |=> (tmr_o == $past(delay_i)));

  p_tmr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!tick_en_i && !(pkt_done_i && (|delay_i))) |=> $stable(tmr_o));

  p_tmr_step_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tick_en_i && !(pkt_done_i && (|delay_i)) && (|tmr_o))
      |=> (tmr_o == ($past(tmr_o) - TMR_W'(1))));

  p_dly_reload_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    dly_set_o |-> (cnt_o == $past(thresh_i)));

  p_dly_zero_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    dly_set_o |-> ((tmr_o == '0) || $past(pkt_done_i && (|delay_i))));

endmodule

bind irq_coalescer irq_coalescer_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_sync_n),
  .thresh_i   (thresh_i),
  .delay_i    (delay_i),
  .pkt_done_i (pkt_done_i),
  .ctrl_wr_i  (ctrl_wr_i),
  .tick_en_i  (tick_en_i),
  .ioc_set_o  (ioc_set_o),
  .dly_set_o  (dly_set_o),
  .cnt_o      (cnt_o),
  .tmr_o      (tmr_o)
);

// File: tb/irq_coalescer_tb.sv
module irq_coalescer_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] thr, dly;
  logic       pd, wr, tk;
  logic       ioc, dset;
  logic [7:0] cnt, tmr;
  int         n_run;
  int         n_fail;
  logic       done;

  irq_coalescer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .thresh_i   (thr),
    .delay_i    (dly),
    .pkt_done_i (pd),
    .ctrl_wr_i  (wr),
    .tick_en_i  (tk),
    .ioc_set_o  (ioc),
    .dly_set_o  (dset),
    .cnt_o      (cnt),
    .tmr_o      (tmr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Row: {thr, dly, pd, wr, tk, exp_cnt, exp_tmr, exp_ioc, exp_dly}
  localparam int NROW = 16;
  localparam logic [36:0] TBL [NROW] = '{
    {8'd3, 8'd4, 1'b0, 1'b1, 1'b0, 8'd3, 8'd0, 1'b0, 1'b0}, // R4 write reload
    {8'd3, 8'd4, 1'b1, 1'b0, 1'b0, 8'd2, 8'd4, 1'b0, 1'b0}, // R2 dec, R5 load
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd2, 8'd3, 1'b0, 1'b0}, // R6 tick
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b0, 8'd2, 8'd3, 1'b0, 1'b0}, // R6 hold
    {8'd3, 8'd4, 1'b1, 1'b0, 1'b0, 8'd1, 8'd4, 1'b0, 1'b0}, // R5 restart
    {8'd3, 8'd4, 1'b1, 1'b0, 1'b1, 8'd3, 8'd4, 1'b1, 1'b0}, // R2 hit, R5 load beats tick
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd3, 8'd3, 1'b0, 1'b0}, // R6
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd3, 8'd2, 1'b0, 1'b0}, // R6
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd3, 8'd1, 1'b0, 1'b0}, // R6
    {8'd5, 8'd4, 1'b0, 1'b0, 1'b1, 8'd5, 8'd0, 1'b0, 1'b1}, // R7 expiry reload
    {8'd5, 8'd4, 1'b0, 1'b0, 1'b1, 8'd5, 8'd0, 1'b0, 1'b0}, // R7 once only
    {8'd5, 8'd0, 1'b1, 1'b0, 1'b0, 8'd4, 8'd0, 1'b0, 1'b0}, // R8 zero delay
    {8'd5, 8'd2, 1'b1, 1'b0, 1'b0, 8'd3, 8'd2, 1'b0, 1'b0}, // R5
    {8'd5, 8'd2, 1'b0, 1'b0, 1'b1, 8'd3, 8'd1, 1'b0, 1'b0}, // R6
    {8'd5, 8'd0, 1'b1, 1'b0, 1'b1, 8'd5, 8'd0, 1'b0, 1'b1}, // R9 same cycle
    {8'd5, 8'd0, 1'b1, 1'b1, 1'b0, 8'd5, 8'd0, 1'b0, 1'b0}  // R10 write wins
  };

  function automatic string row_req(input int i);
    case (i)
      0:        return "R4";
      1, 5:     return "R2";
      4, 12:    return "R5";
      9, 10:    return "R7";
      11:       return "R8";
      14:       return "R9";
      15:       return "R10";
      default:  return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Inputs are set, then one clock edge passes; outputs are read at the next negedge.
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_in();
    pd = 1'b0; wr = 1'b0; tk = 1'b0;
  endtask

  task automatic chk_reset_state(input string tag);
    chk("R1", {tag, " cnt"}, int'(cnt), 1);
    chk("R1", {tag, " tmr"}, int'(tmr), 0);
    chk("R1", {tag, " pulses"}, int'({ioc, dset}), 0);
  endtask

  initial begin
    done = 1'b0;
    #(4 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int ioc_seen;
    logic [7:0] ecnt, etmr;
    logic       eioc, edly;
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    thr = 8'd0;
    dly = 8'd0;
    idle_in();
    repeat (3) @(negedge clk);
    chk_reset_state("in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_reset_state("after release");

    // Table walk
    for (int i = 0; i < NROW; i++) begin
      {thr, dly, pd, wr, tk, ecnt, etmr, eioc, edly} = TBL[i];
      cyc();
      idle_in();
      chk(row_req(i), $sformatf("row %0d cnt", i), int'(cnt), int'(ecnt));
      chk(row_req(i), $sformatf("row %0d tmr", i), int'(tmr), int'(etmr));
      chk(row_req(i), $sformatf("row %0d ioc", i), int'(ioc), int'(eioc));
      chk(row_req(i), $sformatf("row %0d dly", i), int'(dset), int'(edly));
    end

    // R3: threshold 0 wraps, 256 completions per interrupt
    thr = 8'd0; dly = 8'd0; wr = 1'b1;
    cyc(); idle_in();
    chk("R4", "zero threshold load", int'(cnt), 0);
    ioc_seen = 0;
    for (int k = 0; k < 255; k++) begin
      pd = 1'b1;
      cyc(); idle_in();
      if (ioc) ioc_seen++;
      if (k == 0) chk("R3", "first wrap value", int'(cnt), 255);
    end
    chk("R3", "no pulse in 255", ioc_seen, 0);
    chk("R3", "count after 255", int'(cnt), 1);
    pd = 1'b1;
    cyc(); idle_in();
    chk("R3", "pulse on 256th", int'(ioc), 1);
    chk("R3", "reload to 0", int'(cnt), 0);

    // R9: expiry and terminal completion together
    thr = 8'd1; dly = 8'd1; wr = 1'b1;
    cyc(); idle_in();
    pd = 1'b1;
    cyc(); idle_in();
    chk("R2", "threshold 1 pulse", int'(ioc), 1);
    chk("R5", "delay 1 load", int'(tmr), 1);
    pd = 1'b1; tk = 1'b1;
    cyc(); idle_in();
    chk("R9", "ioc", int'(ioc), 1);
    chk("R9", "dly", int'(dset), 1);
    chk("R9", "cnt", int'(cnt), 1);
    chk("R9", "tmr restart", int'(tmr), 1);
    tk = 1'b1;
    cyc(); idle_in();
    chk("R7", "second run expiry", int'(dset), 1);
    chk("R7", "tmr at zero", int'(tmr), 0);

    // R10: write and terminal completion together
    thr = 8'd2; dly = 8'd0; wr = 1'b1;
    cyc(); idle_in();
    pd = 1'b1;
    cyc(); idle_in();
    chk("R2", "dec to 1", int'(cnt), 1);
    thr = 8'd7; pd = 1'b1; wr = 1'b1;
    cyc(); idle_in();
    chk("R10", "ioc kept", int'(ioc), 1);
    chk("R10", "cnt threshold", int'(cnt), 7);
    chk("R4", "no dly pulse", int'(dset), 0);

    // R1: reset in the middle of a run
    dly = 8'd9; pd = 1'b1;
    cyc(); idle_in();
    #1 rst_n = 1'b0;
    #1;
    chk_reset_state("mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_reset_state("mid-run release");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule